// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the full double-width product of two unsigned integers (32 bits each by default) over several clock cycles. It does not use a single-cycle array multiplier. It keeps three registers:

- a double-width multiplicand register that moves one place left per step;
- a single-width multiplier register that moves one place right per step;
- a double-width accumulator that collects the partial sums.

On every step, the multiplicand is added into the accumulator only when the lowest multiplier bit is one. A double-width adder forms that sum.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` then stays high for exactly one cycle per multiplier bit. `done` pulses for one cycle when the last step has been written. The product stays on `product` until the next accepted start. A start that arrives while the block is busy is dropped.

Top module: `mul_shift_add`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 loads the operands. In the following cycle `busy` is 1 and `product` reads 0.
- R3: When `done` is 1, `product` equals the unsigned product of the two operands captured at the accepted start, over the full double-width result.
- R4: The block performs exactly W steps, one per multiplier bit. `busy` is high for exactly W cycles, and `done` is seen W cycles after the edge that accepted `start`.
- R5: `done` is high for a single cycle only, and `busy` is 0 whenever `done` is 1.
- R6: A `start` sampled while `busy` is 1 has no effect: neither the final product nor the cycle on which `done` appears changes.
- R7: While the block is idle and no start is accepted, `product` holds its value.
- R8: After the first step, `product` equals `op_a` when bit 0 of `op_b` was 1, and 0 when it was 0. A step adds the shifted multiplicand only when the current lowest multiplier bit is 1.
- R9: A `start` in the same cycle as `done` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | W | Multiplicand operand |
| op_b | input | W | Multiplier operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*W | Accumulated product |

## Verification
The bench sweeps every operand pair of a 6-bit configuration. This catches:

- a lost carry into the upper half, which shows as wrong results for large operands such as all-ones times all-ones;
- an off-by-one step count, which shows as `done` appearing one cycle early or late, or as a top multiplier bit that is never added.

The first-step check catches an inverted or misrouted add condition: such a design shows a nonzero partial product for an even multiplier.

Starts injected mid-operation with different operands expose a design that reloads while busy; its result or its completion time would change.

Starts issued in the `done` cycle expose a design that needs an extra idle cycle. Several idle cycles watched after completion expose a product that drifts.

// File: rtl/mul_shift_add_pkg.sv
package mul_shift_add_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

endpackage

// File: rtl/mul_wide_adder.sv
module mul_wide_adder #(
    parameter int N = 64
) (
    input  logic [N-1:0] addend_a,
    input  logic [N-1:0] addend_b,
    output logic [N-1:0] sum
);

    always_comb begin
        sum = addend_a + addend_b;
    end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_shift_add_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    typedef struct packed {
        mul_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_regs_t;

    ctrl_regs_t cur_q;
    ctrl_regs_t nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    load        = 1'b1;
                    nxt_d.state = ST_RUN;
                    nxt_d.cnt   = '0;
                end
            end
            ST_RUN: begin
                step      = 1'b1;
                nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                if (cur_q.cnt == LAST_STEP) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = (cur_q.state == ST_RUN);
    assign done = cur_q.done;

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);

    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] mcand;
        logic [W-1:0]  mplier;
        logic [PW-1:0] acc;
    } dp_regs_t;

    dp_regs_t      cur_q;
    dp_regs_t      nxt_d;
    logic [PW-1:0] sum_w;

    mul_wide_adder #(.N(PW)) adder_i (
        .addend_a (cur_q.acc),
        .addend_b (cur_q.mcand),
        .sum      (sum_w)
    );

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.mcand  = {{W{1'b0}}, op_a};
            nxt_d.mplier = op_b;
            nxt_d.acc    = '0;
        end else if (step) begin
            if (cur_q.mplier[0]) begin
                nxt_d.acc = sum_w;
            end
            nxt_d.mcand  = {cur_q.mcand[PW-2:0], 1'b0};
            nxt_d.mplier = {1'b0, cur_q.mplier[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign product = cur_q.acc;

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);

    logic load_w;
    logic step_w;

    mul_ctrl #(.W(W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load_w),
        .step  (step_w),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.W(W)) dp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .step    (step_w),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

endmodule

// File: rtl/mul_shift_add_chk.sv
module mul_shift_add_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);

    localparam int RW = $clog2(W + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == '0));

    // R4
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == RW'(W)));

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(W)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_q < RW'(W - 1)) |=> busy);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind mul_shift_add mul_shift_add_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/mul_shift_add_tb_top.sv
module mul_shift_add_tb_top;

    localparam int W  = 6;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mul_shift_add #(.W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        return PW'(a) * PW'(b);
    endfunction

    // Start an operation and follow it to done; leaves time at the negedge where done is seen.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && product == '0, "R2", longint'(product), 0);
        cyc = 1;
        @(negedge clk);
        cyc = 2;
        check(product == (b[0] ? PW'(a) : PW'(0)), "R8", longint'(product),
              longint'(b[0] ? PW'(a) : PW'(0)));
        if (inject) begin
            start = 1'b1;
            op_a  = ~a;
            op_b  = ~b;
            @(negedge clk);
            cyc++;
            start = 1'b0;
        end
        while (!done && cyc < W + 6) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == W + 1, "R4", cyc, W + 1);
        check(product == ref_mul(a, b), inject ? "R6" : "R3",
              longint'(product), longint'(ref_mul(a, b)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1",
              longint'({busy, done}), 0);
        rst_n = 1'b1;

        // R3: exhaustive sweep of every operand pair
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                run_op(W'(ia), W'(ib), 1'b0);
            end
        end

        // R6: starts while busy are dropped
        run_op('1, '1, 1'b1);
        run_op(W'(5), W'(0), 1'b1);
        run_op(W'(0), W'(9), 1'b1);

        // R5 and R7: single-cycle done, held product
        run_op(W'(37), W'(22), 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(done == 1'b0, "R5", done, 0);
            check(product == ref_mul(W'(37), W'(22)), "R7",
                  longint'(product), longint'(ref_mul(W'(37), W'(22))));
        end

        // R9: start issued in the done cycle
        run_op(W'(11), W'(13), 1'b0);
        start = 1'b1;
        op_a  = W'(63);
        op_b  = W'(2);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && product == '0, "R9", longint'(busy), 1);
        while (!done) @(negedge clk);
        check(product == ref_mul(W'(63), W'(2)), "R9",
              longint'(product), longint'(ref_mul(W'(63), W'(2))));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule